// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block sits between a 32-bit load/store port and a memory bus that can move either a single word or a four-word burst. Every access carries a physical address and a two-bit page mode that selects how the access is treated: cached with write-through, cached with copyback, uncached, or uncached I/O. The cache stores 4 KB of data, organised as 64 sets with four ways each. Each line holds four 32-bit words.

Cached reads that hit return data on the cycle after the request. A cached miss refills the whole line with a four-beat read burst. If the victim line is dirty, a four-beat write-back burst of that line comes first. Uncached and I/O accesses each go to the bus as a single beat and never touch the cache state. The controller accepts one access at a time, so every access completes in the order it was issued. The controller is busy from the cycle after it accepts an access until that access's response.

Top module: `dcache_ctrl`

## Requirements
- R1: Address split: word select is addr[3:2], set index is addr[9:4] (64 sets), and tag is addr[31:10]. Two addresses hit the same line only when both their set and their tag match.
- R2: A cached read hit raises `rsp_valid` with the line word on the cycle after acceptance, with no bus activity.
- R3: A cached read miss issues a four-beat read burst (`mem_burst`=1) to the line base, with word addresses 0,1,2,3 in order. It then responds with the requested word, and the line becomes resident.
- R4: Mode code 2'b00 is write-through. A store hit updates the cached word and issues one single-beat write (`mem_burst`=0) with the store's byte enables. The response follows the bus acknowledge.
- R5: A write-through store miss issues one single-beat write and allocates no line, so a later read of that address misses.
- R6: Mode code 2'b01 is copyback. A store hit updates only the cached line, marks it dirty, causes no bus activity and responds on the next cycle.
- R7: A copyback store miss refills the line by burst, merges the store into it and leaves the line dirty.
- R8: Evicting a dirty line first writes all four of its words by burst to the victim's own address. Only after the last write-back beat does the refill burst start.
- R9: Mode code 2'b10 is uncached. The access is a single bus beat, a read returns bus data even when the line is resident, and a store leaves any cached copy unchanged.
- R10: Mode code 2'b11 is uncached I/O. Each access is one single beat, never a burst. Accesses complete one at a time in issue order. While a bus request is pending, `cpu_busy` is high, and the address, direction and burst flag hold steady until acknowledged.
- R11: The victim is the lowest-numbered invalid way. When all four ways are valid, a per-set pointer starting at way 0 picks the victim and advances by one after each such pick.
- R12: Byte enable bit b (`cpu_be`) gates byte lane b (bits 8b+7:8b). Lanes with a clear enable keep their old value.
- R13: After reset there is no valid line, and `cpu_busy`, `mem_req` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Access request, taken when `cpu_busy` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Physical byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_mode | input | 2 | Page mode: 00 write-through, 01 copyback, 10 uncached, 11 uncached I/O |
| cpu_busy | output | 1 | Access in progress; new requests not taken |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with `rsp_valid` |
| mem_req | output | 1 | Bus request, held until each beat is acknowledged |
| mem_we | output | 1 | Bus direction, 1 = write |
| mem_burst | output | 1 | 1 = part of a four-beat line burst |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_wdata | output | 32 | Write data for the current beat |
| mem_be | output | 4 | Byte enables for the current beat |
| mem_ack | input | 1 | Beat accepted or read data valid |
| mem_rdata | input | 32 | Read data for the current beat |

## Verification
The hardest case to reach from the ports is a dirty eviction chosen by the round-robin pointer. It needs a copyback store to dirty a way, three more allocations to fill the set, and then one further miss to the same set. The stimulus does this on purpose in set 3, and then follows with a pseudo-random stream over a small pool of tags and sets, so that pointer wrap, dirty write-backs and refills stack up. The bench keeps its own model of tags, dirty bits, pointers and memory. From that model it predicts every bus beat and response, while the bus responder inserts wait states.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

   typedef enum logic [1:0] {
      CM_WTHRU   = 2'b00,
      CM_COPYBK  = 2'b01,
      CM_NOCACHE = 2'b10,
      CM_IOSEQ   = 2'b11
   } cmode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVICT,
      ST_REFILL,
      ST_MERGE,
      ST_DIRECT
   } cstate_e;

   function automatic logic mode_cacheable(cmode_e m);
      return (m == CM_WTHRU) || (m == CM_COPYBK);
   endfunction

endpackage

// File: rtl/dcache_tags.sv
module dcache_tags #(
   parameter int SETS  = 64,
   parameter int WAYS  = 4,
   parameter int TAG_W = 22,
   parameter int SET_W = 6,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   output logic [WAYS-1:0]  hit_vec,
   output logic [WAYS-1:0]  val_vec,
   output logic [WAYS-1:0]  dty_vec,
   input  logic [WAY_W-1:0] rd_way,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_dirty
);

   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [WAYS-1:0]  val_q [SETS];
   logic [WAYS-1:0]  dty_q [SETS];

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            val_q[s] <= '0;
            dty_q[s] <= '0;
         end
      end else if (wr_en) begin
         val_q[wr_set][wr_way] <= 1'b1;
         dty_q[wr_set][wr_way] <= wr_dirty;
      end
   end

   assign val_vec = val_q[lk_set];
   assign dty_vec = dty_q[lk_set];
   assign rd_tag  = tag_q[lk_set][rd_way];

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = val_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
   end

endmodule

// File: rtl/dcache_victim.sv
module dcache_victim #(
   parameter int SETS  = 64,
   parameter int WAYS  = 4,
   parameter int SET_W = 6,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_i,
   input  logic [WAYS-1:0]  val_vec,
   input  logic             adv,
   output logic [WAY_W-1:0] victim
);

   if (WAYS == 1) begin : g_direct
      assign victim = '0;
      logic unused_vic;
      assign unused_vic = ^{clk, rst_n, set_i, val_vec, adv};
   end else begin : g_rr
      logic [WAY_W-1:0] rr_q [SETS];
      logic [WAY_W-1:0] free_way;
      logic             any_free;

      always_comb begin
         free_way = '0;
         any_free = 1'b0;
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (!val_vec[w]) begin
               free_way = WAY_W'(w);
               any_free = 1'b1;
            end
         end
      end

      assign victim = any_free ? free_way : rr_q[set_i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
         end else if (adv && !any_free) begin
            rr_q[set_i] <= rr_q[set_i] + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dcache_data.sv
module dcache_data #(
   parameter int DATA_W = 32,
   parameter int SET_W  = 6,
   parameter int WAY_W  = 2,
   parameter int WORD_W = 2
) (
   input  logic                clk,
   input  logic [SET_W-1:0]    rd_set,
   input  logic [WAY_W-1:0]    rd_way,
   input  logic [WORD_W-1:0]   rd_word,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                wr_en,
   input  logic [SET_W-1:0]    wr_set,
   input  logic [WAY_W-1:0]    wr_way,
   input  logic [WORD_W-1:0]   wr_word,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic [DATA_W-1:0]   wr_data
);

   localparam int IDX_W = SET_W + WAY_W + WORD_W;
   localparam int DEPTH = 1 << IDX_W;
   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] words_q [DEPTH];
   logic [IDX_W-1:0]  wr_idx;

   assign wr_idx  = {wr_set, wr_way, wr_word};
   assign rd_data = words_q[{rd_set, rd_way, rd_word}];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int b = 0; b < LANES; b++) begin
            if (wr_be[b]) words_q[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
         end
      end
   end

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
   import dcache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SETS       = 64,
   parameter int WAYS       = 4,
   parameter int LINE_WORDS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [DATA_W-1:0]   cpu_wdata,
   input  logic [DATA_W/8-1:0] cpu_be,
   input  logic [1:0]          cpu_mode,
   output logic                cpu_busy,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic                mem_burst,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic [DATA_W/8-1:0] mem_be,
   input  logic                mem_ack,
   input  logic [DATA_W-1:0]   mem_rdata
);

   localparam int LANES  = DATA_W / 8;
   localparam int BYTE_W = $clog2(LANES);
   localparam int WORD_W = $clog2(LINE_WORDS);
   localparam int OFF_W  = WORD_W + BYTE_W;
   localparam int SET_W  = $clog2(SETS);
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 1 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 16");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the cache geometry");
   end

   cstate_e             st_q;
   logic [ADDR_W-1:0]   a_q;
   logic                we_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [LANES-1:0]    be_q;
   cmode_e              mode_q;
   logic [WAY_W-1:0]    way_q;
   logic [WORD_W-1:0]   beat_q;
   logic                rsp_valid_q;
   logic [DATA_W-1:0]   rsp_rdata_q;

   cmode_e              in_mode;
   logic [ADDR_W-1:0]   lk_addr;
   logic [SET_W-1:0]    lk_set;
   logic [TAG_W-1:0]    lk_tag;
   logic [WORD_W-1:0]   lk_word;
   logic [WAYS-1:0]     hit_vec, val_vec, dty_vec;
   logic                hit_any;
   logic [WAY_W-1:0]    hit_way, victim, rd_way;
   logic [TAG_W-1:0]    rd_tag;
   logic                accept, in_cache, last_beat, alloc;
   logic [WORD_W-1:0]   rd_word;
   logic [DATA_W-1:0]   rd_data;

   logic                d_wr;
   logic [WAY_W-1:0]    d_way;
   logic [WORD_W-1:0]   d_word;
   logic [LANES-1:0]    d_be;
   logic [DATA_W-1:0]   d_data;
   logic                t_wr, t_dirty;
   logic [WAY_W-1:0]    t_way;

   assign in_mode   = cmode_e'(cpu_mode);
   assign lk_addr   = (st_q == ST_IDLE) ? cpu_addr : a_q;
   assign lk_set    = lk_addr[OFF_W +: SET_W];
   assign lk_tag    = lk_addr[ADDR_W-1 -: TAG_W];
   assign lk_word   = lk_addr[BYTE_W +: WORD_W];
   assign accept    = cpu_req && (st_q == ST_IDLE);
   assign in_cache  = mode_cacheable(in_mode);
   assign hit_any   = |hit_vec;
   assign last_beat = (beat_q == WORD_W'(LINE_WORDS - 1));
   assign alloc     = accept && in_cache && !hit_any && !(cpu_we && in_mode == CM_WTHRU);

   logic unused_lsb;
   assign unused_lsb = ^{cpu_addr[BYTE_W-1:0], a_q[BYTE_W-1:0]};

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   dcache_tags #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
   ) u_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_set(lk_set), .lk_tag(lk_tag),
      .hit_vec(hit_vec), .val_vec(val_vec), .dty_vec(dty_vec),
      .rd_way(way_q), .rd_tag(rd_tag),
      .wr_en(t_wr), .wr_set(lk_set), .wr_way(t_way), .wr_tag(lk_tag), .wr_dirty(t_dirty)
   );

   dcache_victim #(
      .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
   ) u_victim (
      .clk(clk), .rst_n(rst_n),
      .set_i(lk_set), .val_vec(val_vec), .adv(alloc), .victim(victim)
   );

   assign rd_way  = (st_q == ST_IDLE) ? hit_way : way_q;
   assign rd_word = (st_q == ST_EVICT) ? beat_q : lk_word;

   dcache_data #(
      .DATA_W(DATA_W), .SET_W(SET_W), .WAY_W(WAY_W), .WORD_W(WORD_W)
   ) u_data (
      .clk(clk),
      .rd_set(lk_set), .rd_way(rd_way), .rd_word(rd_word), .rd_data(rd_data),
      .wr_en(d_wr), .wr_set(lk_set), .wr_way(d_way), .wr_word(d_word),
      .wr_be(d_be), .wr_data(d_data)
   );

   // Array write steering: store hit, refill beat, post-refill merge.
   always_comb begin
      d_wr    = 1'b0;
      d_way   = way_q;
      d_word  = lk_word;
      d_be    = cpu_be;
      d_data  = cpu_wdata;
      t_wr    = 1'b0;
      t_way   = way_q;
      t_dirty = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (accept && in_cache && hit_any && cpu_we) begin
               d_wr  = 1'b1;
               d_way = hit_way;
               t_way = hit_way;
               if (in_mode == CM_COPYBK) begin
                  t_wr    = 1'b1;
                  t_dirty = 1'b1;
               end
            end
         end
         ST_REFILL: begin
            if (mem_ack) begin
               d_wr   = 1'b1;
               d_word = beat_q;
               d_be   = '1;
               d_data = mem_rdata;
               t_wr   = last_beat;
            end
         end
         ST_MERGE: begin
            if (we_q) begin
               d_wr   = 1'b1;
               d_be   = be_q;
               d_data = wdata_q;
               if (mode_q == CM_COPYBK) begin
                  t_wr    = 1'b1;
                  t_dirty = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         a_q         <= '0;
         we_q        <= 1'b0;
         wdata_q     <= '0;
         be_q        <= '0;
         mode_q      <= CM_WTHRU;
         way_q       <= '0;
         beat_q      <= '0;
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  a_q     <= cpu_addr;
                  we_q    <= cpu_we;
                  wdata_q <= cpu_wdata;
                  be_q    <= cpu_be;
                  mode_q  <= in_mode;
                  beat_q  <= '0;
                  if (in_cache && hit_any) begin
                     way_q <= hit_way;
                     if (cpu_we && in_mode == CM_WTHRU) begin
                        st_q <= ST_DIRECT;
                     end else begin
                        rsp_valid_q <= 1'b1;
                        if (!cpu_we) rsp_rdata_q <= rd_data;
                     end
                  end else if (!alloc) begin
                     st_q <= ST_DIRECT;
                  end else begin
                     way_q <= victim;
                     st_q  <= (val_vec[victim] && dty_vec[victim]) ? ST_EVICT : ST_REFILL;
                  end
               end
            end
            ST_EVICT: begin
               if (mem_ack) begin
                  beat_q <= beat_q + 1'b1;
                  if (last_beat) st_q <= ST_REFILL;
               end
            end
            ST_REFILL: begin
               if (mem_ack) begin
                  beat_q <= beat_q + 1'b1;
                  if (last_beat) st_q <= ST_MERGE;
               end
            end
            ST_MERGE: begin
               rsp_valid_q <= 1'b1;
               if (!we_q) rsp_rdata_q <= rd_data;
               st_q <= ST_IDLE;
            end
            ST_DIRECT: begin
               if (mem_ack) begin
                  rsp_valid_q <= 1'b1;
                  if (!we_q) rsp_rdata_q <= mem_rdata;
                  st_q <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_burst = 1'b0;
      mem_addr  = {lk_tag, lk_set, beat_q, {BYTE_W{1'b0}}};
      mem_wdata = rd_data;
      mem_be    = '1;
      unique case (st_q)
         ST_EVICT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_burst = 1'b1;
            mem_addr  = {rd_tag, lk_set, beat_q, {BYTE_W{1'b0}}};
         end
         ST_REFILL: begin
            mem_req   = 1'b1;
            mem_burst = 1'b1;
         end
         ST_DIRECT: begin
            mem_req   = 1'b1;
            mem_we    = we_q;
            mem_addr  = {a_q[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
            mem_wdata = wdata_q;
            mem_be    = we_q ? be_q : '1;
         end
         default: ;
      endcase
   end

   assign cpu_busy  = (st_q != ST_IDLE);
   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/dcache_ctrl_chk.sv
module dcache_ctrl_chk #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_busy,
   input logic              rsp_valid,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_burst,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic [1:0]        mode_q
);

   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WORD_W = $clog2(LINE_WORDS);
   localparam int OFF_W  = BYTE_W + WORD_W;
   localparam logic [WORD_W-1:0] LAST = WORD_W'(LINE_WORDS - 1);

   // R3: within a burst, an accepted non-final beat is followed by the next word of the same line
   assert_burst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_burst && mem_ack && mem_addr[BYTE_W +: WORD_W] != LAST) |=>
      (mem_req && mem_burst &&
       mem_addr[BYTE_W +: WORD_W] == WORD_W'($past(mem_addr[BYTE_W +: WORD_W]) + 1'b1) &&
       mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));

   // R8: the last write-back beat hands over directly to a refill burst starting at word 0
   assert_evict_then_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_burst && mem_we && mem_ack && mem_addr[BYTE_W +: WORD_W] == LAST) |=>
      (mem_req && mem_burst && !mem_we && mem_addr[BYTE_W +: WORD_W] == '0));

   // R10: a pending beat holds its address, direction and burst flag
   assert_hold_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_burst)));

   // R10: bus activity only while the port is busy
   assert_busy_on_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_busy);

   // R9: uncached and I/O accesses never use a burst
   assert_uncached_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && cpu_busy && mode_q[1]) |-> !mem_burst);

   // R2: a response comes with the port ready and the bus quiet
   assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!cpu_busy && !mem_req));

endmodule

bind dcache_ctrl dcache_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy), .rsp_valid(rsp_valid),
   .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
   .mem_addr(mem_addr), .mem_ack(mem_ack), .mode_q(mode_q)
);

// File: tb/tb_dcache_ctrl.sv
module tb_dcache_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;
   logic [1:0]  cpu_mode = '0;
   logic        cpu_busy, rsp_valid;
   logic [31:0] rsp_rdata;
   logic        mem_req, mem_we, mem_burst;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #10 clk = ~clk;

   dcache_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_be(cpu_be), .cpu_mode(cpu_mode), .cpu_busy(cpu_busy),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      logic [31:0] a;
      logic        we;
      logic        bu;
      logic [31:0] d;
      logic [3:0]  be;
   } beat_t;

   beat_t       exq [$];
   logic [31:0] bmem [int];
   string       cur_req = "R13";

   // reference model state
   logic [21:0] m_tag [64][4];
   bit          m_val [64][4];
   bit          m_dty [64][4];
   logic [31:0] m_dat [64][4][4];
   int          m_rr  [64];

   function automatic logic [31:0] mrd(logic [31:0] a);
      int k = int'(a >> 2);
      if (bmem.exists(k)) return bmem[k];
      return (a ^ 32'h5A00_0000) + 32'h0000_1357;
   endfunction

   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
      logic [31:0] r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
      return r;
   endfunction

   function automatic logic [31:0] mk(int t, int s, int w);
      return (32'(t) << 10) | (32'(s) << 4) | (32'(w) << 2);
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] a, input logic we, input logic bu,
                       input logic [31:0] d, input logic [3:0] be);
      beat_t b;
      b.a = a; b.we = we; b.bu = bu; b.d = d; b.be = be;
      exq.push_back(b);
   endtask

   // bus responder and per-beat comparison against the predicted bus traffic
   always @(negedge clk) begin
      beat_t e;
      cyc++;
      mem_ack = 1'b0;
      if (rst_n && mem_req && (cyc % 3 != 1)) begin
         mem_ack   = 1'b1;
         mem_rdata = mrd(mem_addr);
         if (exq.size() == 0) begin
            chk(1'b0, cur_req, "unexpected bus beat addr", mem_addr, 32'hFFFF_FFFF);
         end else begin
            e = exq.pop_front();
            chk(mem_addr == e.a, cur_req, "beat address", mem_addr, e.a);
            chk(mem_we == e.we && mem_burst == e.bu, cur_req, "beat we/burst",
                {30'd0, mem_we, mem_burst}, {30'd0, e.we, e.bu});
            if (e.we) begin
               chk(mem_wdata == e.d, cur_req, "beat write data", mem_wdata, e.d);
               chk(mem_be == e.be, cur_req, "beat byte enables", {28'd0, mem_be}, {28'd0, e.be});
            end
         end
         if (mem_we) bmem[int'(mem_addr >> 2)] = merge(mrd(mem_addr), mem_wdata, mem_be);
      end
   end

   task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input logic [1:0] md, input string rq);
      int          s = int'(a[9:4]);
      logic [21:0] t = a[31:10];
      int          wd = int'(a[3:2]);
      int          hw = -1;
      int          v = -1;
      int          lat;
      bit          fast = 1'b0;
      bit          chk_d = 1'b0;
      logic [31:0] exp_d = '0;
      logic [31:0] wa = {a[31:2], 2'b00};
      cur_req = rq;
      if (md < 2) begin
         for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == t) hw = w;
      end
      if (md >= 2) begin
         push(wa, we, 1'b0, d, we ? be : 4'hF);
         if (!we) begin exp_d = mrd(a); chk_d = 1'b1; end
      end else if (hw >= 0) begin
         if (!we) begin
            exp_d = m_dat[s][hw][wd]; chk_d = 1'b1; fast = 1'b1;
         end else begin
            m_dat[s][hw][wd] = merge(m_dat[s][hw][wd], d, be);
            if (md == 1) begin m_dty[s][hw] = 1'b1; fast = 1'b1; end
            else push(wa, 1'b1, 1'b0, d, be);
         end
      end else if (we && md == 0) begin
         push(wa, 1'b1, 1'b0, d, be);
      end else begin
         for (int w = 0; w < 4; w++) if (!m_val[s][w] && v < 0) v = w;
         if (v < 0) begin v = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % 4; end
         if (m_val[s][v] && m_dty[s][v]) begin
            for (int k = 0; k < 4; k++)
               push({m_tag[s][v], 6'(s), 2'(k), 2'b00}, 1'b1, 1'b1, m_dat[s][v][k], 4'hF);
         end
         for (int k = 0; k < 4; k++) begin
            push({t, 6'(s), 2'(k), 2'b00}, 1'b0, 1'b1, 32'd0, 4'hF);
            m_dat[s][v][k] = mrd({t, 6'(s), 2'(k), 2'b00});
         end
         m_val[s][v] = 1'b1;
         m_tag[s][v] = t;
         m_dty[s][v] = 1'b0;
         if (we) begin
            m_dat[s][v][wd] = merge(m_dat[s][v][wd], d, be);
            m_dty[s][v] = (md == 1);
         end else begin
            exp_d = m_dat[s][v][wd]; chk_d = 1'b1;
         end
      end
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_mode = md;
      @(negedge clk);
      cpu_req = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 300) begin
         @(negedge clk);
         lat++;
      end
      chk(rsp_valid, rq, "response seen", {31'd0, rsp_valid}, 32'd1);
      if (fast) chk(lat == 1, rq, "hit latency", 32'(lat), 32'd1);
      if (chk_d) chk(rsp_rdata == exp_d, rq, "read data", rsp_rdata, exp_d);
      chk(exq.size() == 0, rq, "bus beats outstanding", 32'(exq.size()), 32'd0);
      exq.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=%h expected=%h", cur_req, 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] x = 32'h1234_5678;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13: idle after reset
      chk(!cpu_busy, "R13", "busy after reset", {31'd0, cpu_busy}, 32'd0);
      chk(!mem_req, "R13", "mem_req after reset", {31'd0, mem_req}, 32'd0);
      chk(!rsp_valid, "R13", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

      access(1'b0, mk(1, 1, 0), 0, 4'h0, 2'b00, "R3");
      access(1'b0, mk(1, 1, 0), 0, 4'h0, 2'b00, "R2");
      access(1'b0, mk(1, 1, 3), 0, 4'h0, 2'b00, "R1");
      access(1'b1, mk(1, 1, 2), 32'hDEAD_BEEF, 4'b0011, 2'b00, "R4");
      access(1'b0, mk(1, 1, 2), 0, 4'h0, 2'b00, "R12");
      access(1'b1, mk(7, 2, 1), 32'h1122_3344, 4'hF, 2'b00, "R5");
      access(1'b0, mk(7, 2, 1), 0, 4'h0, 2'b00, "R5");
      access(1'b1, mk(1, 3, 0), 32'hCAFE_0001, 4'hF, 2'b01, "R7");
      access(1'b1, mk(1, 3, 1), 32'h0BAD_0002, 4'b1100, 2'b01, "R6");
      access(1'b0, mk(1, 3, 1), 0, 4'h0, 2'b01, "R12");
      for (int t = 2; t <= 4; t++) access(1'b0, mk(t, 3, 0), 0, 4'h0, 2'b01, "R11");
      access(1'b0, mk(5, 3, 2), 0, 4'h0, 2'b01, "R8");
      access(1'b0, mk(6, 3, 0), 0, 4'h0, 2'b01, "R11");
      access(1'b0, mk(1, 3, 1), 0, 4'h0, 2'b01, "R8");
      access(1'b1, mk(5, 3, 2), 32'h7777_8888, 4'hF, 2'b01, "R6");
      access(1'b0, mk(5, 3, 2), 0, 4'h0, 2'b10, "R9");
      access(1'b1, mk(5, 3, 2), 32'h9999_0000, 4'hF, 2'b10, "R9");
      access(1'b0, mk(5, 3, 2), 0, 4'h0, 2'b01, "R9");
      for (int i = 0; i < 6; i++)
         access(1'(i % 2), mk(9, i, i % 4), 32'hA000_0000 + 32'(i), 4'hF, 2'b11, "R10");
      access(1'b0, mk(1, 1, 0) | 32'h8000_0000, 0, 4'h0, 2'b00, "R1");
      access(1'b0, mk(1, 1, 0), 0, 4'h0, 2'b00, "R1");
      for (int i = 0; i < 300; i++) begin
         x = x * 32'd1103515245 + 32'd12345;
         access(x[20], mk(int'(x[19:17]), int'(x[16:15]), int'(x[14:13])), x,
                x[12:9] | 4'b0001, x[8:7], "R11");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule